// File: doc/BRIEF.md
# Three-Weight Accumulator Pattern Generator

This block produces test stimulus for a circuit under test from an ordinary accumulator. Two registers feed an unmodified adder: the pattern register and an addend register. The sum is written back to the pattern register on each clock. Every bit position takes one of three weights in each session. A weight-1 bit is held at 1, a weight-0 bit is held at 0, and a free bit accumulates with even odds.

A bit is forced by presetting its two adder operands to opposite values. With opposite operands a full adder passes its carry-in straight to its carry-out, so the free bits above a forced bit see the same carry they would see if the forced bit were free. The adder stays a plain `+`, and any adder structure works.

A parameter table holds one weight assignment per session. After `start_i` the block steps through the sessions in order. Each session lasts a fixed number of cycles, or ends early on `adv_i`. After the last session the block raises `done_o` and freezes the pattern.

Top module: `wpg_top`

## Requirements
- R1: While `rst_n` is sampled low on a clock edge, the next state shows `pattern_o` = 0, `session_o` = 0 and `done_o` = 0.
- R2: A `start_i` sampled high while not running (idle or done) starts session 0. From the next cycle `pattern_o` has 1 in the weight-1 positions of session 0 and 0 elsewhere, `session_o` is 0 and `done_o` is 0.
- R3: Position i is weight 1 in session s when bit s*WIDTH+i of `ONE_MAP` is 1. Such a bit reads 1 in every cycle of session s.
- R4: Position i is weight 0 in session s when bit s*WIDTH+i of `ZERO_MAP` is 1 and the same bit of `ONE_MAP` is 0. Such a bit reads 0 in every cycle of session s. If both map bits are 1, weight 1 wins.
- R5: On each running edge, the next pattern is (pattern + addend) mod 2^WIDTH, with the forced positions of the session then in force written over. The addend bit is 0 for weight 1, 1 for weight 0, and bit i of `FREE_ADDEND` for a free bit. The addend register takes the new session's values on the same edge.
- R6: While running, the pattern and addend bits at every forced position of the current session differ, so a carry crosses that position unchanged.
- R7: A session that is not cut short shows `SESSION_LEN` consecutive patterns. On the edge that ends it, `session_o` increments and the forcing of the next session applies.
- R8: `adv_i` sampled high while running ends the current session on that edge. In the last session it finishes the run.
- R9: When the last session ends, `done_o` becomes 1. `pattern_o` and `session_o` then hold until a new start or a reset, and `adv_i` has no effect.
- R10: `start_i` while running is ignored. The session and its cycle count go on unchanged.
- R11: `adv_i` while idle after reset leaves `pattern_o`, `session_o` and `done_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a run at session 0 when not running |
| adv_i | input | 1 | End the current session early |
| pattern_o | output | WIDTH | Stimulus for the circuit under test (pattern register) |
| session_o | output | max(1, clog2(NUM_SESSIONS)) | Index of the session in force |
| done_o | output | 1 | Run finished, pattern frozen |

## Verification
The bench builds the block 8 bits wide, with three sessions of 10 cycles each. Session 0 mixes weight-1, weight-0 and free bits. Session 1 puts its forced bits above and between free bits, so carries must cross them. Session 2 is fully free. With these values, every kind of session edge can be reached in a few dozen cycles: an end by count, an early end, and a forced end of the last session. The same settings let a cycle-exact model of the carry-through arithmetic be compared on every clock.

// File: rtl/wpg_pkg.sv
// Shared types and helpers for the three-weight pattern generator.
// Assumes nothing beyond IEEE 1800-2017 elaboration-time functions.
package wpg_pkg;

    // Run state of the session sequencer.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

    // Width of a counter or index covering n values, never below one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wpg_session_seq.sv
// Session sequencer: steps through NUM_SESSIONS sessions of SESSION_LEN
// cycles, honouring an early advance request, and tells the accumulator
// which configuration to apply on the current edge (cfg_sel_o).
// Assumes start_i and adv_i are synchronous to clk.
module wpg_session_seq
    import wpg_pkg::*;
#(
    parameter int unsigned NUM_SESSIONS = 2,
    parameter int unsigned SESSION_LEN  = 16,
    localparam int unsigned SES_W = idx_width(NUM_SESSIONS),
    localparam int unsigned CYC_W = idx_width(SESSION_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             adv_i,
    output logic             load_o,
    output logic             step_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [SES_W-1:0] sess_o,
    output logic [SES_W-1:0] cfg_sel_o
);

    seq_state_e       state_q;
    logic [SES_W-1:0] sess_q;
    logic [CYC_W-1:0] cyc_q;
    logic             running;
    logic             last_ses;
    logic             sess_end;

    // Decode session end, start acceptance and the configuration for this edge.
    always_comb begin
        running  = (state_q == SEQ_RUN);
        last_ses = (sess_q == SES_W'(NUM_SESSIONS - 1));
        sess_end = running && (adv_i || (cyc_q == CYC_W'(SESSION_LEN - 1)));
        load_o   = start_i && !running;
        step_o   = running && !(sess_end && last_ses);
        if (load_o) begin
            cfg_sel_o = '0;
        end else if (sess_end && !last_ses) begin
            cfg_sel_o = sess_q + 1'b1;
        end else begin
            cfg_sel_o = sess_q;
        end
        busy_o = running;
        done_o = (state_q == SEQ_DONE);
        sess_o = sess_q;
    end

    // Advance the run state, session index and in-session cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            sess_q  <= '0;
            cyc_q   <= '0;
        end else if (load_o) begin
            state_q <= SEQ_RUN;
            sess_q  <= '0;
            cyc_q   <= '0;
        end else if (running) begin
            if (sess_end) begin
                cyc_q <= '0;
                if (last_ses) begin
                    state_q <= SEQ_DONE;
                end else begin
                    sess_q <= cfg_sel_o;
                end
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wpg_weight_table.sv
// Weight table: returns the weight-1 and weight-0 masks of one session.
// Assumes the maps are packed session by session, session 0 in the low bits.
// A position marked in both maps is treated as weight 1; an out-of-range
// index yields an all-free assignment.
module wpg_weight_table
    import wpg_pkg::*;
#(
    parameter int unsigned WIDTH        = 5,
    parameter int unsigned NUM_SESSIONS = 2,
    parameter logic [WIDTH*NUM_SESSIONS-1:0] ONE_MAP  = '0,
    parameter logic [WIDTH*NUM_SESSIONS-1:0] ZERO_MAP = '0,
    localparam int unsigned SES_W = idx_width(NUM_SESSIONS)
) (
    input  logic [SES_W-1:0] sel_i,
    output logic [WIDTH-1:0] one_o,
    output logic [WIDTH-1:0] zero_o
);

    logic [WIDTH-1:0] one_tab  [NUM_SESSIONS];
    logic [WIDTH-1:0] zero_tab [NUM_SESSIONS];

    for (genvar g = 0; g < NUM_SESSIONS; g++) begin : g_entry
        assign one_tab[g]  = ONE_MAP[g*WIDTH +: WIDTH];
        assign zero_tab[g] = ZERO_MAP[g*WIDTH +: WIDTH] & ~ONE_MAP[g*WIDTH +: WIDTH];
    end

    // Select the masks of the requested session.
    always_comb begin
        one_o  = '0;
        zero_o = '0;
        for (int s = 0; s < NUM_SESSIONS; s++) begin
            if (sel_i == SES_W'(s)) begin
                one_o  = one_tab[s];
                zero_o = zero_tab[s];
            end
        end
    end

endmodule

// File: rtl/wpg_acc_cell.sv
// One bit of the pattern register and of the addend register.
// Forcing presets the two bits to opposite values; a free bit takes the
// adder's sum bit and a fixed addend bit. On a load the free pattern bit
// starts at 0. Assumes one_i and zero_i are never both high.
module wpg_acc_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic step_i,
    input  logic one_i,
    input  logic zero_i,
    input  logic sum_i,
    input  logic seed_i,
    output logic a_o,
    output logic b_o
);

    // Update both operand bits with the override applied after the sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_o <= 1'b0;
            b_o <= 1'b0;
        end else if (load_i || step_i) begin
            if (one_i) begin
                a_o <= 1'b1;
                b_o <= 1'b0;
            end else if (zero_i) begin
                a_o <= 1'b0;
                b_o <= 1'b1;
            end else begin
                a_o <= sum_i & ~load_i;
                b_o <= seed_i;
            end
        end
    end

endmodule

// File: rtl/wpg_top.sv
// Three-weight accumulator pattern generator.
// The pattern register and the addend register feed a plain adder. Per
// session, each bit is forced to 1, forced to 0 or left free. Forcing
// uses complementary operands, so the carry crosses forced bits
// unchanged and the adder needs no change.
// Assumes the weight maps are parameters fixed at build time.
module wpg_top
    import wpg_pkg::*;
#(
    parameter int unsigned WIDTH        = 5,
    parameter int unsigned NUM_SESSIONS = 2,
    parameter int unsigned SESSION_LEN  = 16,
    parameter logic [WIDTH*NUM_SESSIONS-1:0] ONE_MAP  = 10'b00010_00101,
    parameter logic [WIDTH*NUM_SESSIONS-1:0] ZERO_MAP = 10'b00101_00000,
    parameter logic [WIDTH-1:0]              FREE_ADDEND = 5'b11011,
    localparam int unsigned SES_W = idx_width(NUM_SESSIONS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             adv_i,
    output logic [WIDTH-1:0] pattern_o,
    output logic [SES_W-1:0] session_o,
    output logic             done_o
);

    logic             load;
    logic             step;
    logic             busy;
    logic             done;
    logic [SES_W-1:0] sess_cur;
    logic [SES_W-1:0] cfg_sel;
    logic [WIDTH-1:0] one_nxt;
    logic [WIDTH-1:0] zero_nxt;
    logic [WIDTH-1:0] one_cur;
    logic [WIDTH-1:0] zero_cur;
    logic [WIDTH-1:0] reg_a;
    logic [WIDTH-1:0] reg_b;
    logic [WIDTH-1:0] sum;

    wpg_session_seq #(
        .NUM_SESSIONS (NUM_SESSIONS),
        .SESSION_LEN  (SESSION_LEN)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .adv_i     (adv_i),
        .load_o    (load),
        .step_o    (step),
        .busy_o    (busy),
        .done_o    (done),
        .sess_o    (sess_cur),
        .cfg_sel_o (cfg_sel)
    );

    // Masks applied on this edge (for the session that follows it).
    wpg_weight_table #(
        .WIDTH        (WIDTH),
        .NUM_SESSIONS (NUM_SESSIONS),
        .ONE_MAP      (ONE_MAP),
        .ZERO_MAP     (ZERO_MAP)
    ) i_tab_next (
        .sel_i  (cfg_sel),
        .one_o  (one_nxt),
        .zero_o (zero_nxt)
    );

    // Masks of the session now shown at the outputs.
    wpg_weight_table #(
        .WIDTH        (WIDTH),
        .NUM_SESSIONS (NUM_SESSIONS),
        .ONE_MAP      (ONE_MAP),
        .ZERO_MAP     (ZERO_MAP)
    ) i_tab_cur (
        .sel_i  (sess_cur),
        .one_o  (one_cur),
        .zero_o (zero_cur)
    );

    // Unmodified adder; the carry out of the top bit is dropped.
    always_comb begin
        sum = reg_a + reg_b;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        wpg_acc_cell i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load),
            .step_i (step),
            .one_i  (one_nxt[i]),
            .zero_i (zero_nxt[i]),
            .sum_i  (sum[i]),
            .seed_i (FREE_ADDEND[i]),
            .a_o    (reg_a[i]),
            .b_o    (reg_b[i])
        );
    end

    // Drive the block outputs.
    always_comb begin
        pattern_o = reg_a;
        session_o = sess_cur;
        done_o    = done;
    end

endmodule

// File: rtl/wpg_checker.sv
// Assertion checker for wpg_top, attached by bind. It observes the
// outputs, the sequencer busy flag, the current-session masks and both
// operand registers.
module wpg_checker #(
    parameter int unsigned WIDTH        = 5,
    parameter int unsigned NUM_SESSIONS = 2,
    parameter int unsigned SES_W        = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             adv_i,
    input logic             busy,
    input logic [WIDTH-1:0] pattern_o,
    input logic [SES_W-1:0] session_o,
    input logic             done_o,
    input logic [WIDTH-1:0] one_cur,
    input logic [WIDTH-1:0] zero_cur,
    input logic [WIDTH-1:0] reg_a,
    input logic [WIDTH-1:0] reg_b
);

    localparam logic [SES_W-1:0] LAST = SES_W'(NUM_SESSIONS - 1);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pattern_o == '0 && session_o == '0 && !done_o));

    p_weight_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((pattern_o & one_cur) == one_cur));

    p_weight_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((pattern_o & zero_cur) == '0));

    p_carry_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (((reg_a ^ reg_b) & (one_cur | zero_cur)) == (one_cur | zero_cur)));

    p_early_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && adv_i && session_o != LAST) |=> (session_o == $past(session_o) + 1'b1));

    p_done_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(pattern_o) && $stable(session_o)));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done_o && !start_i) |=> ($stable(pattern_o) && !done_o));

endmodule

bind wpg_top wpg_checker #(
    .WIDTH        (WIDTH),
    .NUM_SESSIONS (NUM_SESSIONS),
    .SES_W        (SES_W)
) i_wpg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .adv_i     (adv_i),
    .busy      (busy),
    .pattern_o (pattern_o),
    .session_o (session_o),
    .done_o    (done_o),
    .one_cur   (one_cur),
    .zero_cur  (zero_cur),
    .reg_a     (reg_a),
    .reg_b     (reg_b)
);

// File: tb/test_wpg_top.sv
// Bench for wpg_top: a behavioural model of sessions and the
// carry-through accumulation, compared on every clock, plus directed checks.
`timescale 1ns/1ps
module test_wpg_top;

    localparam int W   = 8;
    localparam int NS  = 3;
    localparam int LEN = 10;
    localparam logic [W*NS-1:0] ONE  = 24'h00_24_81;
    localparam logic [W*NS-1:0] ZERO = 24'h00_C0_10;
    localparam logic [W-1:0]    ADD  = 8'h6B;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          adv_i = 1'b0;
    logic [W-1:0]  pattern_o;
    logic [SW-1:0] session_o;
    logic          done_o;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    wpg_top #(
        .WIDTH(W), .NUM_SESSIONS(NS), .SESSION_LEN(LEN),
        .ONE_MAP(ONE), .ZERO_MAP(ZERO), .FREE_ADDEND(ADD)
    ) i_wpg_top (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .adv_i(adv_i),
        .pattern_o(pattern_o), .session_o(session_o), .done_o(done_o)
    );

    function automatic logic [W-1:0] one_of(input int s);
        return W'(ONE >> (s * W));
    endfunction
    function automatic logic [W-1:0] zero_of(input int s);
        return W'(ZERO >> (s * W)) & ~one_of(s);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---- reference model, updated on each rising edge ----
    bit           m_valid = 0;
    bit           m_busy = 0;
    bit           m_done = 0;
    int           m_sess = 0;
    int           m_cyc = 0;
    logic [W-1:0] m_a = '0;
    logic [W-1:0] m_b = '0;

    function automatic void m_apply(input int s, input bit from_zero);
        logic [W-1:0] f1, f0, nxt;
        f1  = one_of(s);
        f0  = zero_of(s);
        nxt = from_zero ? '0 : W'(m_a + m_b);
        m_a = (nxt & ~(f1 | f0)) | f1;
        m_b = (ADD & ~(f1 | f0)) | f0;
    endfunction

    always @(posedge clk) begin
        m_valid <= 1'b1;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_sess = 0; m_cyc = 0; m_a = '0; m_b = '0;
        end else if (start_i && !m_busy) begin
            m_busy = 1; m_done = 0; m_sess = 0; m_cyc = 0;
            m_apply(0, 1'b1);
        end else if (m_busy) begin
            if (adv_i || m_cyc == LEN - 1) begin
                m_cyc = 0;
                if (m_sess == NS - 1) begin
                    m_busy = 0; m_done = 1;
                end else begin
                    m_sess++;
                    m_apply(m_sess, 1'b0);
                end
            end else begin
                m_cyc++;
                m_apply(m_sess, 1'b0);
            end
        end
    end

    // ---- per-cycle comparison and free-bit toggle tracking ----
    logic [W-1:0] tog [NS];
    logic [W-1:0] prev_pat = '0;
    int           prev_sess = -1;

    always @(negedge clk) begin
        if (m_valid) begin
            check(pattern_o == m_a, "R5", "pattern vs model", int'(pattern_o), int'(m_a));
            check(int'(session_o) == m_sess, "R7", "session vs model", int'(session_o), m_sess);
            check(done_o == m_done, "R9", "done vs model", int'(done_o), int'(m_done));
            if (m_busy) begin
                check((pattern_o & one_of(m_sess)) == one_of(m_sess), "R3",
                      "weight-1 bits", int'(pattern_o), int'(one_of(m_sess)));
                check((pattern_o & zero_of(m_sess)) == '0, "R4",
                      "weight-0 bits", int'(pattern_o & zero_of(m_sess)), 0);
                if (prev_sess == m_sess)
                    tog[m_sess] |= (pattern_o ^ prev_pat) & ~(one_of(m_sess) | zero_of(m_sess));
                prev_sess = m_sess;
            end else begin
                prev_sess = -1;
            end
            prev_pat = pattern_o;
        end
    end

    // ---- watchdog ----
    initial begin
        #100000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // ---- directed sequence ----
    initial begin
        int n;
        logic [W-1:0] held;
        for (int s = 0; s < NS; s++) tog[s] = '0;

        repeat (3) @(negedge clk);
        check(pattern_o == '0 && session_o == '0 && !done_o, "R1", "reset state",
              int'(pattern_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: advance while idle
        adv_i = 1'b1;
        @(negedge clk);
        adv_i = 1'b0;
        @(negedge clk);
        check(pattern_o == '0 && session_o == '0 && !done_o, "R11", "idle advance",
              int'(pattern_o), 0);

        // R2: start loads session 0 forcing
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(pattern_o == one_of(0), "R2", "first pattern", int'(pattern_o), int'(one_of(0)));
        check(session_o == '0 && !done_o, "R2", "session after start", int'(session_o), 0);

        // R7 / R10: session 0 length, with an ignored start in the middle
        n = 0;
        while (session_o == '0 && n < 100) begin
            start_i = (n == 3);
            n++;
            @(negedge clk);
        end
        start_i = 1'b0;
        check(n == LEN, "R10", "start while running ignored (session 0 length)", n, LEN);

        n = 0;
        while (!done_o && n < 100) begin
            n++;
            @(negedge clk);
        end
        check(n == 2 * LEN, "R7", "sessions 1 and 2 length", n, 2 * LEN);

        // R9: frozen after done, advance ignored
        held = pattern_o;
        for (int k = 0; k < 5; k++) begin
            adv_i = (k == 1);
            @(negedge clk);
        end
        adv_i = 1'b0;
        check(pattern_o == held && done_o, "R9", "pattern frozen", int'(pattern_o), int'(held));
        check(int'(session_o) == NS - 1, "R9", "session frozen", int'(session_o), NS - 1);

        // R5 / R6: free bits moved in every session (carry crossed forced bits)
        for (int s = 0; s < NS; s++)
            check(tog[s] != '0, "R6", "free bits toggled in session", int'(tog[s]), 1);

        // R10: restart from done
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!done_o && session_o == '0 && pattern_o == one_of(0), "R10", "restart",
              int'(pattern_o), int'(one_of(0)));
        @(negedge clk);

        // R8: early advance through every session
        adv_i = 1'b1;
        @(negedge clk);
        adv_i = 1'b0;
        check(session_o == 2'd1, "R8", "advance to session 1", int'(session_o), 1);
        check((pattern_o & one_of(1)) == one_of(1), "R8", "session 1 forcing",
              int'(pattern_o), int'(one_of(1)));
        adv_i = 1'b1;
        @(negedge clk);
        adv_i = 1'b0;
        check(session_o == 2'd2, "R8", "advance to session 2", int'(session_o), 2);
        adv_i = 1'b1;
        @(negedge clk);
        adv_i = 1'b0;
        check(done_o, "R8", "advance in last session finishes", int'(done_o), 1);

        // R1: reset in the middle of a run
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(pattern_o == '0 && session_o == '0 && !done_o, "R1", "reset mid-run",
              int'(pattern_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule